// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block is a memory-mapped calendar clock that sits in the top eight byte locations of a byte-wide, SRAM-style bus. It keeps seven packed-BCD counters: seconds, minutes, hours (24-hour), weekday, day of month, month and two-digit year. A one-pulse-per-second strobe from an external prescaler advances them. Software never reads the counters directly. It sees a bank of visible registers that copy the counters on every cycle unless software holds them. One control bit freezes the view so that a multi-byte read stays consistent. A second control bit freezes the view and lets software load a new time. Clearing that bit moves all seven fields into the counters in one cycle.

Two bits outside the control byte act without the load procedure. The halt bit in the seconds byte stops counting. The test bit in the weekday byte replaces bit 0 of the seconds readback with a square wave, which comes from a second prescaler strobe. The bus is synchronous: a write is taken on the clock edge while the write enable is high, and read data follow the address combinationally.

Top module: `rtc_bank`

## Requirements
- R1: The window is byte addresses 7F8h to 7FFh. Offsets 0 to 7 are control, seconds, minutes, hours, weekday, day of month, month and year. `hit_o` is high only inside the window. Reads outside the window return 00h.
- R2: After reset the bank reads control 00h, seconds 80h (halt set), minutes 00h, hours 00h, weekday 01h, day of month 01h, month 01h and year 00h.
- R3: Each `sec_tick_i` pulse with the halt bit clear advances seconds in BCD. The carry ripples 59 to 00 into minutes, 59 to 00 into hours, and 23 to 00 into weekday (7 wraps to 1) and day of month.
- R4: The day of month wraps to 01 after the last day of its month: 28 for February, 29 for February in a year divisible by 4, 30 for April, June, September and November, and 31 otherwise. The month then advances, and December wraps to January with the year incrementing (99 wraps to 00).
- R5: While control bits 7 and 6 are both 0, the visible registers show the counter values, one cycle after the counters change.
- R6: Control bit 6 (read hold) set to 1 freezes the visible time fields while counting continues. After it is cleared, the fields show the current count.
- R7: Control bit 7 (load hold) set to 1 freezes the view and makes time writes take effect. Writing control with bit 7 = 0 while it was 1 loads all seven fields into the counters at once, and ticks then count on from the loaded time.
- R8: While control bit 7 is 0, writes to the time fields of offsets 1 to 7 are ignored. Only the halt and test bits are taken.
- R9: Seconds bit 7 is the halt bit. While it is 1 no tick changes the count. It can be set or cleared with control bit 7 at 0.
- R10: Weekday bit 6 is the test bit and can be written with control bit 7 at 0. While it is 1, seconds readback bit 0 is a test bit. That bit starts at 0 and inverts on each `test_tick_i` pulse while the halt bit is 0. While the test bit is 0, `test_tick_i` has no effect on readback.
- R11: Fixed-zero bits read 0 whatever was written. These are control bits 5:0, minutes bit 7, hours bits 7:6, weekday bits 7 and 5:3, day-of-month bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (11) | Byte address |
| we_i | input | 1 | Write enable, taken on the rising edge |
| wdata_i | input | 8 | Write data |
| sec_tick_i | input | 1 | One-cycle strobe per second |
| test_tick_i | input | 1 | Strobe at twice the test frequency; each pulse inverts the test bit |
| hit_o | output | 1 | Address is inside the clock window |
| rdata_o | output | 8 | Read data for the addressed byte |

## Verification
A wrong carry or month-length decision shows in the visible registers one cycle after the tick that crosses the boundary. The bench therefore sets each boundary just before the tick and reads every affected field straight after. A copy path that ignores the holds shows up as a moved seconds value after several ticks under a read hold. A broken transfer shows up as a loaded time that fails to appear, or that does not count on from the first following tick. Test-bit faults show in the seconds readback right after a single test strobe.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG  = 8;
  localparam int OFF_W = $clog2(NREG);

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } rtc_time_t;

  localparam rtc_time_t TIME_RST = '{yr: 8'h00, mon: 8'h01, date: 8'h01, day: 8'h01,
                                     hr: 8'h00, min: 8'h00, sec: 8'h00};

  function automatic logic [7:0] bcd_inc(logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // (10*t + u) mod 4 == (2*t + u) mod 4
  function automatic logic is_leap(logic [7:0] y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return s[1:0] == 2'd0;
  endfunction

  function automatic logic [7:0] month_last(logic [7:0] m, logic [7:0] y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // writable bits of each time byte; halt and test bits are held apart
  function automatic logic [7:0] field_mask(logic [OFF_W-1:0] off);
    case (off)
      3'd1, 3'd2: return 8'h7F;
      3'd3, 3'd5: return 8'h3F;
      3'd4:       return 8'h07;
      3'd6:       return 8'h1F;
      3'd7:       return 8'hFF;
      default:    return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      run_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  output rtc_time_t cnt_o
);
  rtc_time_t cnt_q, nxt;

  always_comb begin
    nxt = cnt_q;
    if (cnt_q.sec >= 8'h59) begin
      nxt.sec = 8'h00;
      if (cnt_q.min >= 8'h59) begin
        nxt.min = 8'h00;
        if (cnt_q.hr >= 8'h23) begin
          nxt.hr  = 8'h00;
          nxt.day = (cnt_q.day >= 8'h07) ? 8'h01 : bcd_inc(cnt_q.day);
          if (cnt_q.date >= month_last(cnt_q.mon, cnt_q.yr)) begin
            nxt.date = 8'h01;
            if (cnt_q.mon >= 8'h12) begin
              nxt.mon = 8'h01;
              nxt.yr  = (cnt_q.yr >= 8'h99) ? 8'h00 : bcd_inc(cnt_q.yr);
            end else begin
              nxt.mon = bcd_inc(cnt_q.mon);
            end
          end else begin
            nxt.date = bcd_inc(cnt_q.date);
          end
        end else begin
          nxt.hr = bcd_inc(cnt_q.hr);
        end
      end else begin
        nxt.min = bcd_inc(cnt_q.min);
      end
    end else begin
      nxt.sec = bcd_inc(cnt_q.sec);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= TIME_RST;
    else if (load_i)          cnt_q <= load_val_i;
    else if (tick_i && run_i) cnt_q <= nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [7:0]       wdata_i,
  input  rtc_time_t        cnt_i,
  output rtc_time_t        vis_o,
  output logic             rd_halt_o,
  output logic             wr_halt_o,
  output logic             stop_o,
  output logic             ft_o,
  output logic             load_o
);
  rtc_time_t  vis_q;
  logic       rd_halt_q, wr_halt_q, stop_q, ft_q;
  logic [7:0] wval;

  assign wval   = wdata_i & field_mask(off_i);
  assign load_o = we_i && (off_i == '0) && wr_halt_q && !wdata_i[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_halt_q <= 1'b0;
      wr_halt_q <= 1'b0;
      stop_q    <= 1'b1;
      ft_q      <= 1'b0;
    end else if (we_i) begin
      case (off_i)
        3'd0: begin
          rd_halt_q <= wdata_i[6];
          wr_halt_q <= wdata_i[7];
        end
        3'd1:    stop_q <= wdata_i[7];
        3'd4:    ft_q   <= wdata_i[6];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q <= TIME_RST;
    end else if (!rd_halt_q && !wr_halt_q) begin
      vis_q <= cnt_i;
    end else if (wr_halt_q && we_i) begin
      case (off_i)
        3'd1:    vis_q.sec  <= wval;
        3'd2:    vis_q.min  <= wval;
        3'd3:    vis_q.hr   <= wval;
        3'd4:    vis_q.day  <= wval;
        3'd5:    vis_q.date <= wval;
        3'd6:    vis_q.mon  <= wval;
        3'd7:    vis_q.yr   <= wval;
        default: ;
      endcase
    end
  end

  assign vis_o     = vis_q;
  assign rd_halt_o = rd_halt_q;
  assign wr_halt_o = wr_halt_q;
  assign stop_o    = stop_q;
  assign ft_o      = ft_q;
endmodule

// File: rtl/rtc_ftest.sv
module rtc_ftest (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic run_i,
  input  logic tick_i,
  output logic bit_o
);
  logic bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              bit_q <= 1'b0;
    else if (!en_i)           bit_q <= 1'b0;
    else if (tick_i && run_i) bit_q <= ~bit_q;
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/rtc_bank.sv
module rtc_bank
  import rtc_pkg::*;
#(
  parameter int                ADDR_W    = 11,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 11'h7F8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  input  logic              sec_tick_i,
  input  logic              test_tick_i,
  output logic              hit_o,
  output logic [7:0]        rdata_o
);
  logic [OFF_W-1:0] off;
  logic             hit;
  rtc_time_t        cnt_q, vis_q;
  logic             rd_halt, wr_halt, stop, ft, load, test_bit;
  logic [7:0]       bytes [NREG];

  assign hit = addr_i[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W];
  assign off = addr_i[OFF_W-1:0];

  rtc_regs u_regs (
    .clk_i, .rst_ni,
    .we_i      (we_i && hit),
    .off_i     (off),
    .wdata_i,
    .cnt_i     (cnt_q),
    .vis_o     (vis_q),
    .rd_halt_o (rd_halt),
    .wr_halt_o (wr_halt),
    .stop_o    (stop),
    .ft_o      (ft),
    .load_o    (load)
  );

  rtc_counter u_cnt (
    .clk_i, .rst_ni,
    .tick_i     (sec_tick_i),
    .run_i      (!stop),
    .load_i     (load),
    .load_val_i (vis_q),
    .cnt_o      (cnt_q)
  );

  rtc_ftest u_ft (
    .clk_i, .rst_ni,
    .en_i   (ft),
    .run_i  (!stop),
    .tick_i (test_tick_i),
    .bit_o  (test_bit)
  );

  // fixed-zero bits are already cleared in the stored bytes
  assign bytes[0] = {wr_halt, rd_halt, 6'b0};
  assign bytes[1] = {stop | vis_q.sec[7], vis_q.sec[6:1], ft ? test_bit : vis_q.sec[0]};
  assign bytes[2] = vis_q.min;
  assign bytes[3] = vis_q.hr;
  assign bytes[4] = {vis_q.day[7], ft | vis_q.day[6], vis_q.day[5:0]};
  assign bytes[5] = vis_q.date;
  assign bytes[6] = vis_q.mon;
  assign bytes[7] = vis_q.yr;

  assign hit_o   = hit;
  assign rdata_o = hit ? bytes[off] : 8'h00;
endmodule

// File: rtl/rtc_bank_chk.sv
module rtc_bank_chk
  import rtc_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input rtc_time_t cnt_i,
  input rtc_time_t vis_i,
  input logic      rd_halt_i,
  input logic      wr_halt_i,
  input logic      stop_i,
  input logic      load_i
);
  a_r5_copy_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_halt_i && !wr_halt_i) |=> (vis_i == $past(cnt_i)));

  a_r6_view_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_halt_i && !wr_halt_i) |=> $stable(vis_i));

  a_r7_load_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_i == $past(vis_i)));

  a_r7_hold_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !wr_halt_i);

  a_r9_halt_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !load_i) |=> $stable(cnt_i));
endmodule

bind rtc_bank rtc_bank_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt_q),
  .vis_i     (vis_q),
  .rd_halt_i (rd_halt),
  .wr_halt_i (wr_halt),
  .stop_i    (stop),
  .load_i    (load)
);

// File: tb/tb_rtc_bank.sv
module tb_rtc_bank;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] addr = 11'h000;
  logic        we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic        sec_tick = 1'b0;
  logic        test_tick = 1'b0;
  logic        hit;
  logic [7:0]  rdata;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  rtc_bank dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .sec_tick_i(sec_tick), .test_tick_i(test_tick), .hit_o(hit), .rdata_o(rdata)
  );

  localparam logic [10:0] BASE = 11'h7F8;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reg(string req, int off, logic [7:0] exp);
    @(negedge clk);
    addr = BASE + 11'(off);
    #1 check(req, rdata, exp);
  endtask

  task automatic wr(int off, logic [7:0] d);
    @(negedge clk);
    addr = BASE + 11'(off); wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk) sec_tick = 1'b1;
    @(negedge clk) sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ttick();
    @(negedge clk) test_tick = 1'b1;
    @(negedge clk) test_tick = 1'b0;
  endtask

  task automatic set_time(logic [7:0] s, mi, h, dy, dt, mo, y);
    wr(0, 8'h80);
    wr(1, s); wr(2, mi); wr(3, h); wr(4, dy); wr(5, dt); wr(6, mo); wr(7, y);
    wr(0, 8'h00);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_reg("R2 ctrl", 0, 8'h00);
    chk_reg("R2 sec", 1, 8'h80);
    chk_reg("R2 min", 2, 8'h00);
    chk_reg("R2 hr", 3, 8'h00);
    chk_reg("R2 day", 4, 8'h01);
    chk_reg("R2 date", 5, 8'h01);
    chk_reg("R2 mon", 6, 8'h01);
    chk_reg("R2 yr", 7, 8'h00);
    @(negedge clk);
    addr = 11'h7F7;
    #1 check("R1 outside data", rdata, 8'h00);
    check("R1 outside hit", {7'b0, hit}, 8'h00);
    addr = 11'h7FF;
    #1 check("R1 inside hit", {7'b0, hit}, 8'h01);
  endtask

  task automatic t_stop();
    tick();
    chk_reg("R9 halted tick", 1, 8'h80);
    wr(1, 8'h00);
    chk_reg("R9 halt cleared w/o load hold", 1, 8'h00);
    wr(1, 8'h25);
    chk_reg("R8 seconds write ignored", 1, 8'h00);
    tick();
    chk_reg("R3 R5 first tick", 1, 8'h01);
  endtask

  task automatic t_reserved();
    wr(0, 8'hBF);
    chk_reg("R11 ctrl low bits", 0, 8'h80);
    wr(2, 8'h85); wr(3, 8'hE5); wr(4, 8'hB5); wr(5, 8'hC7); wr(6, 8'hE9);
    chk_reg("R11 min", 2, 8'h05);
    chk_reg("R11 hr", 3, 8'h25);
    chk_reg("R11 day", 4, 8'h05);
    chk_reg("R11 date", 5, 8'h07);
    chk_reg("R11 mon", 6, 8'h09);
    wr(0, 8'h00);
  endtask

  task automatic t_carry();
    set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
    chk_reg("R7 loaded sec", 1, 8'h58);
    tick();
    chk_reg("R7 counts from load", 1, 8'h59);
    tick();
    chk_reg("R3 sec wrap", 1, 8'h00);
    chk_reg("R3 min wrap", 2, 8'h00);
    chk_reg("R3 hr wrap", 3, 8'h00);
    chk_reg("R3 day 7->1", 4, 8'h01);
    chk_reg("R4 feb28 nonleap date", 5, 8'h01);
    chk_reg("R4 feb28 nonleap mon", 6, 8'h03);
    chk_reg("R4 year kept", 7, 8'h23);
  endtask

  task automatic t_months();
    set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
    tick();
    chk_reg("R4 leap feb29 date", 5, 8'h29);
    chk_reg("R4 leap feb29 mon", 6, 8'h02);
    chk_reg("R3 day inc", 4, 8'h04);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
    tick();
    chk_reg("R4 leap end date", 5, 8'h01);
    chk_reg("R4 leap end mon", 6, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h23);
    tick();
    chk_reg("R4 30-day date", 5, 8'h01);
    chk_reg("R4 30-day mon", 6, 8'h05);
    set_time(8'h59, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
    tick();
    chk_reg("R4 year end date", 5, 8'h01);
    chk_reg("R4 year end mon", 6, 8'h01);
    chk_reg("R4 year 99->00", 7, 8'h00);
    chk_reg("R3 day 6->7", 4, 8'h07);
  endtask

  task automatic t_read_hold();
    set_time(8'h30, 8'h20, 8'h10, 8'h02, 8'h15, 8'h06, 8'h23);
    wr(0, 8'h40);
    chk_reg("R6 ctrl readback", 0, 8'h40);
    tick(); tick(); tick();
    chk_reg("R6 frozen sec", 1, 8'h30);
    wr(2, 8'h45);
    wr(0, 8'h00);
    @(negedge clk);
    chk_reg("R6 resumed sec", 1, 8'h33);
    chk_reg("R8 min write ignored", 2, 8'h20);
  endtask

  task automatic t_ftest();
    wr(4, 8'h40);
    chk_reg("R10 test bit readback", 4, 8'h42);
    chk_reg("R10 bit0 starts 0", 1, 8'h32);
    ttick();
    chk_reg("R10 bit0 toggles", 1, 8'h33);
    ttick();
    chk_reg("R10 bit0 toggles back", 1, 8'h32);
    wr(1, 8'h80);
    ttick();
    chk_reg("R10 R9 no toggle while halted", 1, 8'hB2);
    wr(1, 8'h00);
    wr(4, 8'h00);
    chk_reg("R10 test off sec", 1, 8'h33);
    ttick();
    chk_reg("R10 strobe ignored when off", 1, 8'h33);
    chk_reg("R10 day restored", 4, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_stop();
    t_reserved();
    t_carry();
    t_months();
    t_read_hold();
    t_ftest();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule